// File: doc/BRIEF.md
# Infrared Receive Byte Queue with Interrupt Flags

The block sits behind an infrared pulse encoder. The encoder pushes one run-length byte at a time into a first-in first-out queue. When it sees the end of a burst, it pulses a packet-end input. Software on a plain register bus pops the bytes one read at a time. It can see how many bytes wait in the queue inside the status word, and it acknowledges events by writing ones to the status bits.

Three events are recorded as flags:
- **Overflow:** a byte was lost because the queue was full.
- **Packet end:** the encoder marked the end of a burst.
- **Data available:** the fill exceeded a programmable trigger level.

Each flag has an enable bit. A single interrupt line is high while any enabled flag is set. Software usually programs the trigger level to half the depth minus one. It is then interrupted once the queue is half full and can drain it in one pass.

Top module: `ir_rxq`

Register map (word address on `bus_addr`):

| Address | Register | Access | Fields |
|---|---|---|---|
| 0 | Data | read | Reading pops one byte from the queue. |
| 1 | Status | read, write-one-to-clear | Overflow in bit 0, packet end in bit 1, data available in bit 4, byte count starting at bit 8. |
| 2 | Enable | read/write | Overflow enable in bit 0, packet-end enable in bit 1, data-available enable in bit 4, trigger level starting at bit 8. |

The count field and the trigger field are each CW = log2(2*DEPTH) bits wide. All other bits read as zero.

## Requirements
- R1: After reset the status word, the enable word and `irq` are all zero.
- R2: Bytes pushed with `push_vld` are stored in order. Each `bus_rd` at address 0 returns the oldest byte on `bus_rdata[7:0]` in the same cycle and removes it at the clock edge.
- R3: A push into a full queue without a pop in the same cycle drops the byte and sets overflow (status bit 0) at that edge. The stored bytes are unchanged.
- R4: A read of address 0 while the queue is empty returns zero and leaves the count at zero.
- R5: The status word reports the number of stored bytes in bits [8 +: CW] and never more than DEPTH.
- R6: A `pkt_end` pulse sets packet end (status bit 1) at the next clock edge.
- R7: Data available (status bit 4) is set at the edge after any cycle whose count exceeds the trigger level (enable word bits [8 +: CW]). It stays set after the count drops. A clear takes effect only while the count no longer exceeds the trigger.
- R8: Writing the status word clears exactly the flags written as 1 and leaves the others. Writing 0xFF clears all flags. A flag being set in the same cycle as its clear stays set.
- R9: The enable word reads back as written. `irq` is high exactly when some flag is set and its enable bit (same bit position) is 1.
- R10: A push and a pop in the same cycle on a full queue both take effect: no overflow, the count stays DEPTH, and the pushed byte comes out last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| push_vld | input | 1 | Push strobe from the encoder |
| push_data | input | 8 | Run-length byte to store |
| pkt_end | input | 1 | End-of-burst pulse from the encoder |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops at address 0) |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register, combinational |
| irq | output | 1 | Interrupt, high while any enabled flag is set |

## Verification
The bound checker watches, on every cycle:
- the count bound;
- that a dropped push raises overflow;
- that an empty read returns zero and leaves the count at zero;
- that packet end and the trigger comparison set their flags one edge later;
- that pops decrement the count;
- that a simultaneous push and pop on a full queue keeps the count at DEPTH.

Only the directed scenarios show the remaining behaviour:
- byte ordering through the queue;
- the exact data lost on overflow;
- the stickiness of data available once the count falls;
- selective write-one-to-clear and the set-over-clear priority;
- the mapping from enables to the interrupt line.

// File: rtl/ir_rxq_pkg.sv
package ir_rxq_pkg;
  localparam int REG_AW = 2;

  typedef enum logic [REG_AW-1:0] {
    RA_DATA = 2'd0,
    RA_STAT = 2'd1,
    RA_IEN  = 2'd2,
    RA_NONE = 2'd3
  } reg_addr_e;

  // bit positions shared by the status and enable words
  localparam int B_OVF   = 0;
  localparam int B_PE    = 1;
  localparam int B_DA    = 4;
  localparam int B_FIELD = 8;

  // flag vector order inside the block
  localparam int NFLAG = 3;
  localparam int F_OVF = 0;
  localparam int F_PE  = 1;
  localparam int F_DA  = 2;
endpackage

// File: rtl/ir_rxq_fifo.sv
module ir_rxq_fifo #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_vld,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop_req,
  output logic [DATA_W-1:0] rd_data,
  output logic [CW-1:0]     count,
  output logic              full,
  output logic              push_drop
);
  logic [AW-1:0]     wr_ptr_q, wr_ptr_d;
  logic [AW-1:0]     rd_ptr_q, rd_ptr_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic              empty, do_pop, do_push;
  logic [DATA_W-1:0] mem [DEPTH];

  assign empty     = (cnt_q == '0);
  assign full      = (cnt_q == CW'(DEPTH));
  assign do_pop    = pop_req && !empty;
  assign do_push   = push_vld && (!full || do_pop);
  assign push_drop = push_vld && !do_push;

  // storage: one clock-enabled byte register per entry, no reset
  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic ent_en;
    assign ent_en = do_push && (wr_ptr_q == AW'(i));
    always_ff @(posedge clk) begin
      if (ent_en) mem[i] <= push_data;
    end
  end

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (do_push) wr_ptr_d = wr_ptr_q + AW'(1);
    if (do_pop)  rd_ptr_d = rd_ptr_q + AW'(1);
    case ({do_push, do_pop})
      2'b10:   cnt_d = cnt_q + CW'(1);
      2'b01:   cnt_d = cnt_q - CW'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  assign rd_data = empty ? '0 : mem[rd_ptr_q];
  assign count   = cnt_q;
endmodule

// File: rtl/ir_rxq_flags.sv
module ir_rxq_flags #(
  parameter int NF = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set_i,
  input  logic [NF-1:0] clr_i,
  output logic [NF-1:0] flag_o
);
  logic [NF-1:0] flag_q, flag_d;

  // per flag: setting has priority over a simultaneous clear
  for (genvar i = 0; i < NF; i++) begin : g_flag
    always_comb begin
      if (set_i[i])      flag_d[i] = 1'b1;
      else if (clr_i[i]) flag_d[i] = 1'b0;
      else               flag_d[i] = flag_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/ir_rxq_regs.sv
module ir_rxq_regs
  import ir_rxq_pkg::*;
#(
  parameter int BUS_W  = 32,
  parameter int DATA_W = 8,
  parameter int CW     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [DATA_W-1:0] fifo_data,
  input  logic [CW-1:0]     fifo_count,
  input  logic [NFLAG-1:0]  flags,
  output logic              pop_req,
  output logic [NFLAG-1:0]  clr,
  output logic [CW-1:0]     trig,
  output logic              irq
);
  logic [NFLAG-1:0] en_q, en_d;
  logic [CW-1:0]    trig_q, trig_d;
  logic             wr_ien, wr_stat;
  logic             unused_wdata;

  assign unused_wdata = ^bus_wdata;

  assign wr_ien  = bus_wr && (bus_addr == RA_IEN);
  assign wr_stat = bus_wr && (bus_addr == RA_STAT);
  assign pop_req = bus_rd && (bus_addr == RA_DATA);

  always_comb begin
    clr = '0;
    if (wr_stat) begin
      clr[F_OVF] = bus_wdata[B_OVF];
      clr[F_PE]  = bus_wdata[B_PE];
      clr[F_DA]  = bus_wdata[B_DA];
    end
  end

  always_comb begin
    en_d   = en_q;
    trig_d = trig_q;
    if (wr_ien) begin
      en_d[F_OVF] = bus_wdata[B_OVF];
      en_d[F_PE]  = bus_wdata[B_PE];
      en_d[F_DA]  = bus_wdata[B_DA];
      trig_d      = bus_wdata[B_FIELD +: CW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      trig_q <= '0;
    end else begin
      en_q   <= en_d;
      trig_q <= trig_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      RA_DATA: bus_rdata[DATA_W-1:0] = fifo_data;
      RA_STAT: begin
        bus_rdata[B_OVF]         = flags[F_OVF];
        bus_rdata[B_PE]          = flags[F_PE];
        bus_rdata[B_DA]          = flags[F_DA];
        bus_rdata[B_FIELD +: CW] = fifo_count;
      end
      RA_IEN: begin
        bus_rdata[B_OVF]         = en_q[F_OVF];
        bus_rdata[B_PE]          = en_q[F_PE];
        bus_rdata[B_DA]          = en_q[F_DA];
        bus_rdata[B_FIELD +: CW] = trig_q;
      end
      default: bus_rdata = '0;
    endcase
  end

  assign trig = trig_q;
  assign irq  = |(flags & en_q);
endmodule

// File: rtl/ir_rxq.sv
module ir_rxq
  import ir_rxq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  parameter int BUS_W  = 32,
  localparam int CW    = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_vld,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pkt_end,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              irq
);
  logic              rst_meta_n, rst_q_n;
  logic              pop_req, fifo_full, push_drop;
  logic [DATA_W-1:0] fifo_data;
  logic [CW-1:0]     fifo_count, trig;
  logic [NFLAG-1:0]  flag_set, flag_clr, flags;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_q_n    <= rst_meta_n;
    end
  end

  ir_rxq_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .push_vld  (push_vld),
    .push_data (push_data),
    .pop_req   (pop_req),
    .rd_data   (fifo_data),
    .count     (fifo_count),
    .full      (fifo_full),
    .push_drop (push_drop)
  );

  always_comb begin
    flag_set        = '0;
    flag_set[F_OVF] = push_drop;
    flag_set[F_PE]  = pkt_end;
    flag_set[F_DA]  = (fifo_count > trig);
  end

  ir_rxq_flags #(.NF(NFLAG)) u_flags (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .set_i  (flag_set),
    .clr_i  (flag_clr),
    .flag_o (flags)
  );

  ir_rxq_regs #(.BUS_W(BUS_W), .DATA_W(DATA_W), .CW(CW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .fifo_data  (fifo_data),
    .fifo_count (fifo_count),
    .flags      (flags),
    .pop_req    (pop_req),
    .clr        (flag_clr),
    .trig       (trig),
    .irq        (irq)
  );
endmodule

// File: rtl/ir_rxq_chk.sv
module ir_rxq_chk
  import ir_rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int BUS_W = 32,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic              push_vld,
  input logic              pkt_end,
  input logic              bus_rd,
  input logic [REG_AW-1:0] bus_addr,
  input logic [BUS_W-1:0]  bus_rdata,
  input logic [CW-1:0]     fifo_count,
  input logic              fifo_full,
  input logic [CW-1:0]     trig,
  input logic [NFLAG-1:0]  flags
);
  logic rd_data_c, pop_c;
  assign rd_data_c = bus_rd && (bus_addr == RA_DATA);
  assign pop_c     = rd_data_c && (fifo_count != '0);

  // R5
  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_q_n)
    fifo_count <= CW'(DEPTH));

  // R3
  a_r3_overflow_set: assert property (@(posedge clk) disable iff (!rst_q_n)
    (push_vld && fifo_full && !pop_c) |=> flags[F_OVF]);

  // R4
  a_r4_empty_zero: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rd_data_c && fifo_count == '0) |-> (bus_rdata == '0));

  // R4
  a_r4_empty_hold: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rd_data_c && fifo_count == '0 && !push_vld) |=> (fifo_count == '0));

  // R6
  a_r6_pkt_end: assert property (@(posedge clk) disable iff (!rst_q_n)
    pkt_end |=> flags[F_PE]);

  // R7
  a_r7_da_set: assert property (@(posedge clk) disable iff (!rst_q_n)
    (fifo_count > trig) |=> flags[F_DA]);

  // R2
  a_r2_pop_dec: assert property (@(posedge clk) disable iff (!rst_q_n)
    (pop_c && !push_vld) |=> (fifo_count == $past(fifo_count) - CW'(1)));

  // R10
  a_r10_full_swap: assert property (@(posedge clk) disable iff (!rst_q_n)
    (push_vld && fifo_full && pop_c) |=> (fifo_count == CW'(DEPTH)));
endmodule

bind ir_rxq ir_rxq_chk #(.DEPTH(DEPTH), .BUS_W(BUS_W)) u_chk (
  .clk        (clk),
  .rst_q_n    (rst_q_n),
  .push_vld   (push_vld),
  .pkt_end    (pkt_end),
  .bus_rd     (bus_rd),
  .bus_addr   (bus_addr),
  .bus_rdata  (bus_rdata),
  .fifo_count (fifo_count),
  .fifo_full  (fifo_full),
  .trig       (trig),
  .flags      (flags)
);

// File: tb/ir_rxq_bench.sv
`timescale 1ns/1ps
module ir_rxq_bench;
  localparam int DEPTH = 16;
  localparam int CW    = 5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        push_vld, pkt_end, bus_wr, bus_rd;
  logic [7:0]  push_data;
  logic [1:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  ir_rxq #(.DEPTH(DEPTH)) u_ir_rxq (
    .clk(clk), .rst_n(rst_n), .push_vld(push_vld), .push_data(push_data),
    .pkt_end(pkt_end), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_b(input logic [7:0] d);
    push_vld = 1'b1; push_data = d;
    @(negedge clk);
    push_vld = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #2 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a;
    #2 d = bus_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  function automatic logic [31:0] cnt_of(input logic [31:0] s);
    return (s >> 8) & ((32'd1 << CW) - 1);
  endfunction

  task automatic drain();
    logic [31:0] s, d;
    peek(2'd1, s);
    for (int i = 0; i < int'(cnt_of(s)); i++) rd(2'd0, d);
  endtask

  task automatic t_reset();
    logic [31:0] s;
    peek(2'd1, s); chk("R1 status", s, 32'h0);
    peek(2'd2, s); chk("R1 enable", s, 32'h0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_order();
    logic [31:0] s, d;
    push_b(8'h11); push_b(8'h22); push_b(8'h33);
    peek(2'd1, s); chk("R5 count 3", cnt_of(s), 32'd3);
    rd(2'd0, d); chk("R2 first", d, 32'h11);
    rd(2'd0, d); chk("R2 second", d, 32'h22);
    rd(2'd0, d); chk("R2 third", d, 32'h33);
    peek(2'd1, s); chk("R5 count 0", cnt_of(s), 32'd0);
    wr(2'd1, 32'hFF);
  endtask

  task automatic t_empty();
    logic [31:0] s, d;
    rd(2'd0, d); chk("R4 empty data", d, 32'h0);
    peek(2'd1, s); chk("R4 count stays 0", cnt_of(s), 32'd0);
  endtask

  task automatic t_overflow();
    logic [31:0] s, d;
    for (int i = 0; i < DEPTH; i++) push_b(8'(i * 3 + 1));
    peek(2'd1, s);
    chk("R5 count full", cnt_of(s), DEPTH);
    chk("R3 no ovf yet", s & 32'h1, 32'h0);
    push_b(8'hEE);
    peek(2'd1, s);
    chk("R3 ovf set", s & 32'h1, 32'h1);
    chk("R3 count held", cnt_of(s), DEPTH);
    for (int i = 0; i < DEPTH; i++) begin
      rd(2'd0, d);
      chk("R3 contents kept", d, 32'(8'(i * 3 + 1)));
    end
    wr(2'd1, 32'hFF);
  endtask

  task automatic t_full_swap();
    logic [31:0] s, d;
    for (int i = 0; i < DEPTH; i++) push_b(8'(8'h80 + i));
    push_vld = 1'b1; push_data = 8'h5A; bus_addr = 2'd0; bus_rd = 1'b1;
    #2 d = bus_rdata;
    @(negedge clk);
    push_vld = 1'b0; bus_rd = 1'b0;
    chk("R10 popped oldest", d, 32'h80);
    peek(2'd1, s);
    chk("R10 no ovf", s & 32'h1, 32'h0);
    chk("R10 count full", cnt_of(s), DEPTH);
    for (int i = 0; i < DEPTH; i++) rd(2'd0, d);
    chk("R10 last byte", d, 32'h5A);
    wr(2'd1, 32'hFF);
  endtask

  task automatic t_pkt_end();
    logic [31:0] s;
    pkt_end = 1'b1;
    @(negedge clk);
    pkt_end = 1'b0;
    peek(2'd1, s); chk("R6 pe set", s & 32'h2, 32'h2);
    wr(2'd1, 32'hFF);
  endtask

  task automatic t_da();
    logic [31:0] s, d;
    wr(2'd2, 32'd3 << 8);
    wr(2'd1, 32'hFF);
    push_b(8'h01); push_b(8'h02); push_b(8'h03);
    idle(1);
    peek(2'd1, s); chk("R7 da clear at level", s & 32'h10, 32'h0);
    push_b(8'h04);
    idle(1);
    peek(2'd1, s); chk("R7 da above level", s & 32'h10, 32'h10);
    wr(2'd1, 32'h10);
    peek(2'd1, s); chk("R7 clear ignored while above", s & 32'h10, 32'h10);
    rd(2'd0, d);
    idle(1);
    peek(2'd1, s); chk("R7 da sticky", s & 32'h10, 32'h10);
    wr(2'd1, 32'h10);
    peek(2'd1, s); chk("R7 da cleared", s & 32'h10, 32'h0);
    drain();
    wr(2'd1, 32'hFF);
  endtask

  task automatic t_w1c();
    logic [31:0] s;
    wr(2'd2, 32'd31 << 8);
    for (int i = 0; i <= DEPTH; i++) push_b(8'(i));
    pkt_end = 1'b1; @(negedge clk); pkt_end = 1'b0;
    peek(2'd1, s); chk("R8 both flags", s & 32'h13, 32'h3);
    wr(2'd1, 32'h1);
    peek(2'd1, s); chk("R8 selective", s & 32'h13, 32'h2);
    wr(2'd1, 32'hFF);
    peek(2'd1, s); chk("R8 clear all", s & 32'hFF, 32'h0);
    pkt_end = 1'b1; bus_addr = 2'd1; bus_wdata = 32'h2; bus_wr = 1'b1;
    @(negedge clk);
    pkt_end = 1'b0; bus_wr = 1'b0;
    peek(2'd1, s); chk("R8 set wins", s & 32'h2, 32'h2);
    drain();
    wr(2'd1, 32'hFF);
  endtask

  task automatic t_irq();
    logic [31:0] s;
    pkt_end = 1'b1; @(negedge clk); pkt_end = 1'b0;
    #2 chk("R9 masked", {31'd0, irq}, 32'd0);
    wr(2'd2, (32'd31 << 8) | 32'h2);
    peek(2'd2, s); chk("R9 readback", s, (32'd31 << 8) | 32'h2);
    chk("R9 irq pe", {31'd0, irq}, 32'd1);
    wr(2'd1, 32'h2);
    #2 chk("R9 irq drop", {31'd0, irq}, 32'd0);
    wr(2'd2, 32'h10);
    push_b(8'h77);
    idle(1);
    #2 chk("R9 irq da", {31'd0, irq}, 32'd1);
    wr(2'd2, 32'h1);
    #2 chk("R9 irq other enable", {31'd0, irq}, 32'd0);
    drain();
    wr(2'd1, 32'hFF);
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; push_vld = 1'b0; push_data = '0; pkt_end = 1'b0;
    bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    idle(3);
    rst_n = 1'b1;
    idle(3);
    t_reset();
    t_order();
    t_empty();
    t_overflow();
    t_full_swap();
    t_pkt_end();
    t_da();
    t_w1c();
    t_irq();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule